// File: doc/BRIEF.md
# Three-Wire Serial Control Slave

This block is the target side of a three-wire microcontroller control bus with a clock line, a mode line and a bidirectional data line. Sessions are framed by the level of the mode line. While mode is low, the host sends one selection byte. That byte carries a six-bit device address and a two-bit transfer code. While mode is high, the selected transfer moves register traffic. A write places a 16-bit word into a 7-bit register address. A two-step read first names a register and later asks the device to send back a status byte and the register contents.

The bus inputs arrive already synchronised to the block clock. The block finds rising bus-clock edges itself and takes one data bit on each edge, least significant bit first within every byte. Two strapping inputs set the low half of the variable part of the device address, so up to four of these slaves can share one bus. On the core side, a plain register-file port gives write and read strobes with an address. The register file answers combinationally with read data and a hit flag that marks implemented addresses.

Top module: `tw_ctrl_slave`

## Requirements
- R1: Bits in every byte travel least significant first. A selection byte (taken with mode low) selects the device only when bits 7:2 equal {4'b0001, strap_i[1:0]}, with strap_i[0] in bit 2. With strap 2'b10 this is the address 0,1,1,0,0,0 read from bit 2 upward.
- R2: In a selection byte, bits 1:0 = 2'b10 open a write-or-prepare session and 2'b11 open a read session. The codes 2'b00 and 2'b01 produce no strobe and no drive.
- R3: A selection byte with a non-matching address leaves the block unselected. Following mode-high bytes produce no strobe.
- R4: In a write session, the first mode-high byte with bit 0 = 0 gives the register address in bits 7:1. The next byte is data bits 15:8 and the one after that is bits 7:0. After the last byte there is exactly one reg_wr_o pulse carrying that address and word.
- R5: Once a write or prepare has completed, further mode-high bytes are ignored until a new selection byte arrives.
- R6: A first mode-high byte with bit 0 = 1 records bits 7:1 as the pending read address. A later read session drives three bytes: {pending address in 7:1, flag in bit 0}, then data 15:8, then data 7:0. The flag is 0 when the read is valid.
- R7: An address whose reg_hit_i is low reads back with flag 1 and data 0. A write to such an address gives no reg_wr_o.
- R8: A read session with no earlier prepare returns flag 1, address 0 and data 0, and gives no reg_rd_o.
- R9: bus_data_oe is high only while the device sends its three read bytes and mode is high. It drops in the same cycle that mode falls, and it drops after the third byte.
- R10: The first rising bus-clock edge after reset only wakes the interface and is not taken as a data bit.
- R11: After reset, bus_data_oe, reg_wr_o and reg_rd_o are low, and the two strobes are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_clk_i | input | 1 | Synchronised bus clock, idle high |
| bus_mode_i | input | 1 | Synchronised mode line (low = selection, high = transfer) |
| bus_data_i | input | 1 | Synchronised data line from host |
| bus_data_o | output | 1 | Data bit driven toward host |
| bus_data_oe | output | 1 | Output enable for the data line |
| strap_i | input | 2 | Device address bits 3:2 from pins |
| reg_addr_o | output | 7 | Register address |
| reg_wdata_o | output | 16 | Register write data |
| reg_wr_o | output | 1 | Register write strobe |
| reg_rd_o | output | 1 | Register read strobe |
| reg_rdata_i | input | 16 | Register read data |
| reg_hit_i | input | 1 | Register address is implemented |

## Verification
Every implemented register is written and read back with data patterns computed from its address. This tells apart byte-order faults (high and low byte swapped) from faults in bit order within a byte. All 64 device addresses are swept under one strap setting, and each strap value is then tried with its own address. Together these separate a wrong fixed part of the address from wrong pin positions. All four transfer codes, reads of unimplemented addresses, a read with no prepare, extra bytes after a write, a session with no wake-up pulse and a read stopped by mode falling each cover one decode path that the main sweep never reaches.

// File: rtl/tw_pkg.sv
package tw_pkg;
  // session state of the protocol engine
  typedef enum logic [2:0] {
    S_IDLE,   // not selected
    S_REGB,   // expecting the register byte
    S_DHI,    // expecting data bits 15:8
    S_DLO,    // expecting data bits 7:0
    S_TX,     // sending read bytes
    S_HOLD    // session used up, wait for reselection
  } sess_e;

  // transfer code as it appears in bits 1:0 of the selection byte
  localparam logic [1:0] XFER_WR = 2'b10;
  localparam logic [1:0] XFER_RD = 2'b11;
endpackage

// File: rtl/tw_edge.sv
module tw_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic mode_i,
  output logic rise_o,
  output logic mode_chg_o
);
  logic scl_q, mode_q, awake_q, awake_d, edge_raw;

  assign edge_raw   = scl_i & ~scl_q;
  assign rise_o     = edge_raw & awake_q;
  assign mode_chg_o = mode_i ^ mode_q;

  always_comb begin
    awake_d = awake_q | edge_raw;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q   <= 1'b1;
      mode_q  <= 1'b0;
      awake_q <= 1'b0;
    end else begin
      scl_q   <= scl_i;
      mode_q  <= mode_i;
      awake_q <= awake_d;
    end
  end

  // R10
  wake_before_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rise_o |-> $past(awake_d));
endmodule

// File: rtl/tw_shifter.sv
module tw_shifter #(
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rise_i,
  input  logic          mode_chg_i,
  input  logic          data_i,
  input  logic          load_i,
  input  logic [BW-1:0] load_byte_i,
  output logic [BW-1:0] byte_o,
  output logic          done_o,
  output logic          tx_bit_o
);
  localparam int CW = $clog2(BW);
  localparam logic [CW-1:0] LAST = CW'(BW - 1);

  logic [BW-2:0] sh_q, sh_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [BW-1:0] byte_q, byte_d, tx_q, tx_d;
  logic          done_q, done_d;

  always_comb begin
    sh_d   = sh_q;
    cnt_d  = cnt_q;
    byte_d = byte_q;
    done_d = 1'b0;
    tx_d   = tx_q;
    if (mode_chg_i) begin
      cnt_d = '0;
    end else if (rise_i) begin
      sh_d = {data_i, sh_q[BW-2:1]};
      if (cnt_q == LAST) begin
        cnt_d  = '0;
        byte_d = {data_i, sh_q};
        done_d = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
    if (load_i)      tx_d = load_byte_i;
    else if (rise_i) tx_d = {1'b1, tx_q[BW-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      cnt_q  <= '0;
      byte_q <= '0;
      done_q <= 1'b0;
      tx_q   <= '1;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      byte_q <= byte_d;
      done_q <= done_d;
      tx_q   <= tx_d;
    end
  end

  assign byte_o   = byte_q;
  assign done_o   = done_q;
  assign tx_bit_o = tx_q[0];

  // R1
  done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(rise_i));
  // R1
  done_cnt_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (cnt_q == '0));
endmodule

// File: rtl/tw_proto.sv
module tw_proto
  import tw_pkg::*;
#(
  parameter int BW   = 8,
  parameter int AW   = 7,
  parameter int DW   = 16,
  parameter int PINS = 2,
  parameter logic [BW-3-PINS:0] DEV_HI = 4'b0001
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          done_i,
  input  logic [BW-1:0] byte_i,
  input  logic          mode_i,
  input  logic          mode_chg_i,
  input  logic [PINS-1:0] strap_i,
  input  logic [DW-1:0] reg_rdata_i,
  input  logic          reg_hit_i,
  output logic          load_o,
  output logic [BW-1:0] load_byte_o,
  output logic          oe_o,
  output logic [AW-1:0] reg_addr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic          reg_wr_o,
  output logic          reg_rd_o
);
  localparam int HW = DW / 2;

  sess_e         st_q, st_d;
  logic [AW-1:0] wa_q, wa_d, pa_q, pa_d;
  logic          prep_q, prep_d, rd_ok;
  logic [BW-1:0] whi_q, whi_d;
  logic [DW-1:0] rdat_q, rdat_d;
  logic [1:0]    txi_q, txi_d;
  logic          dev_hit;

  assign dev_hit     = (byte_i[BW-1:2] == {DEV_HI, strap_i});
  assign rd_ok       = prep_q & reg_hit_i;
  assign reg_addr_o  = (st_q == S_DLO) ? wa_q : pa_q;
  assign reg_wdata_o = {whi_q, byte_i};
  assign oe_o        = (st_q == S_TX) & mode_i;

  always_comb begin
    st_d = st_q; wa_d = wa_q; pa_d = pa_q; prep_d = prep_q;
    whi_d = whi_q; rdat_d = rdat_q; txi_d = txi_q;
    load_o = 1'b0; load_byte_o = '0; reg_wr_o = 1'b0; reg_rd_o = 1'b0;
    if (mode_chg_i && !mode_i) begin
      st_d = S_IDLE;
    end else if (done_i && !mode_i) begin
      st_d = S_IDLE;
      if (dev_hit && byte_i[1:0] == XFER_WR) begin
        st_d = S_REGB;
      end else if (dev_hit && byte_i[1:0] == XFER_RD) begin
        st_d        = S_TX;
        txi_d       = 2'd0;
        reg_rd_o    = prep_q;
        rdat_d      = rd_ok ? reg_rdata_i : '0;
        load_o      = 1'b1;
        load_byte_o = {pa_q, ~rd_ok};
      end
    end else if (done_i) begin
      unique case (st_q)
        S_REGB: begin
          if (byte_i[0]) begin
            pa_d = byte_i[BW-1:1]; prep_d = 1'b1; st_d = S_HOLD;
          end else begin
            wa_d = byte_i[BW-1:1]; st_d = S_DHI;
          end
        end
        S_DHI: begin whi_d = byte_i; st_d = S_DLO; end
        S_DLO: begin reg_wr_o = reg_hit_i; st_d = S_HOLD; end
        S_TX: begin
          if (txi_q == 2'd0) begin
            load_o = 1'b1; load_byte_o = rdat_q[DW-1:HW]; txi_d = 2'd1;
          end else if (txi_q == 2'd1) begin
            load_o = 1'b1; load_byte_o = rdat_q[HW-1:0]; txi_d = 2'd2;
          end else begin
            st_d = S_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; wa_q <= '0; pa_q <= '0; prep_q <= 1'b0;
      whi_q <= '0; rdat_q <= '0; txi_q <= '0;
    end else begin
      st_q <= st_d; wa_q <= wa_d; pa_q <= pa_d; prep_q <= prep_d;
      whi_q <= whi_d; rdat_q <= rdat_d; txi_q <= txi_d;
    end
  end

  // R5
  wr_then_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr_o |=> (st_q == S_HOLD));
  // R6
  rd_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_o |=> (st_q == S_TX));
  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr_o && reg_rd_o));
  // R9
  no_drive_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_i |-> !oe_o);
endmodule

// File: rtl/tw_ctrl_slave.sv
module tw_ctrl_slave #(
  parameter int BW   = 8,
  parameter int AW   = 7,
  parameter int DW   = 16,
  parameter int PINS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_clk_i,
  input  logic            bus_mode_i,
  input  logic            bus_data_i,
  output logic            bus_data_o,
  output logic            bus_data_oe,
  input  logic [PINS-1:0] strap_i,
  output logic [AW-1:0]   reg_addr_o,
  output logic [DW-1:0]   reg_wdata_o,
  output logic            reg_wr_o,
  output logic            reg_rd_o,
  input  logic [DW-1:0]   reg_rdata_i,
  input  logic            reg_hit_i
);
  logic [1:0]    rst_sync_q;
  logic          rst_core_n, rise, mode_chg, done, load;
  logic [BW-1:0] rx_byte, load_byte;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  tw_edge u_edge (
    .clk(clk), .rst_n(rst_core_n), .scl_i(bus_clk_i), .mode_i(bus_mode_i),
    .rise_o(rise), .mode_chg_o(mode_chg)
  );

  tw_shifter #(.BW(BW)) u_shift (
    .clk(clk), .rst_n(rst_core_n), .rise_i(rise), .mode_chg_i(mode_chg),
    .data_i(bus_data_i), .load_i(load), .load_byte_i(load_byte),
    .byte_o(rx_byte), .done_o(done), .tx_bit_o(bus_data_o)
  );

  tw_proto #(.BW(BW), .AW(AW), .DW(DW), .PINS(PINS)) u_proto (
    .clk(clk), .rst_n(rst_core_n), .done_i(done), .byte_i(rx_byte),
    .mode_i(bus_mode_i), .mode_chg_i(mode_chg), .strap_i(strap_i),
    .reg_rdata_i(reg_rdata_i), .reg_hit_i(reg_hit_i),
    .load_o(load), .load_byte_o(load_byte), .oe_o(bus_data_oe),
    .reg_addr_o(reg_addr_o), .reg_wdata_o(reg_wdata_o),
    .reg_wr_o(reg_wr_o), .reg_rd_o(reg_rd_o)
  );
endmodule

// File: tb/tb_tw_ctrl_slave.sv
`timescale 1ns/1ps
module tb_tw_ctrl_slave;
  localparam int NIMPL = 16;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n, bclk, bmode, bdin, bdout, boe, rwr, rrd, rhit;
  logic [1:0]  strap;
  logic [6:0]  raddr, last_wa;
  logic [15:0] rwdata, rrdata, last_wd;
  logic [15:0] mem [NIMPL];
  int vectors = 0, miscompares = 0, wr_count = 0, rd_count = 0, oe_bad = 0;
  bit finished = 0;

  assign rhit   = (raddr < NIMPL);
  assign rrdata = rhit ? mem[raddr[3:0]] : 16'hDEAD;

  tw_ctrl_slave dut (
    .clk(clk), .rst_n(rst_n), .bus_clk_i(bclk), .bus_mode_i(bmode),
    .bus_data_i(bdin), .bus_data_o(bdout), .bus_data_oe(boe), .strap_i(strap),
    .reg_addr_o(raddr), .reg_wdata_o(rwdata), .reg_wr_o(rwr), .reg_rd_o(rrd),
    .reg_rdata_i(rrdata), .reg_hit_i(rhit)
  );

  always @(posedge clk) begin
    if (rwr) begin
      wr_count <= wr_count + 1;
      last_wa  <= raddr;
      last_wd  <= rwdata;
      if (raddr < NIMPL) mem[raddr[3:0]] <= rwdata;
    end
    if (rrd) rd_count <= rd_count + 1;
    if (boe && !bmode) oe_bad <= oe_bad + 1;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [5:0] dev_of(input logic [1:0] s);
    return {4'b0001, s};
  endfunction

  function automatic logic [15:0] pat(input int a);
    return 16'(a * 16'h1357) ^ 16'hA5C3;
  endfunction

  task automatic pulse(input logic b);
    @(negedge clk); bdin = b; bclk = 1'b0;
    repeat (2) @(negedge clk);
    bclk = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] v);
    for (int i = 0; i < 8; i++) pulse(v[i]);
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk); bmode = m;
    repeat (3) @(negedge clk);
  endtask

  task automatic recv(output logic [7:0] v, output logic oe_all);
    oe_all = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); bclk = 1'b0;
      repeat (2) @(negedge clk);
      v[i] = bdout; oe_all &= boe;
      bclk = 1'b1;
      repeat (3) @(negedge clk);
    end
  endtask

  task automatic wr(input logic [5:0] dv, input logic [6:0] a, input logic [15:0] d);
    set_mode(1'b0); send({dv, 2'b10});
    set_mode(1'b1); send({a, 1'b0}); send(d[15:8]); send(d[7:0]);
    set_mode(1'b0);
  endtask

  task automatic rd_only(input logic [5:0] dv, output logic [7:0] f,
                         output logic [15:0] d, output logic oe_ok);
    logic [7:0] h, l; logic o0, o1, o2;
    set_mode(1'b0); send({dv, 2'b11});
    set_mode(1'b1); recv(f, o0); recv(h, o1); recv(l, o2);
    @(negedge clk);
    oe_ok = o0 & o1 & o2 & ~boe;   // driven for all three bytes, released after
    d = {h, l};
    set_mode(1'b0);
  endtask

  task automatic rd(input logic [5:0] dv, input logic [6:0] a, output logic [7:0] f,
                    output logic [15:0] d, output logic oe_ok);
    set_mode(1'b0); send({dv, 2'b10});
    set_mode(1'b1); send({a, 1'b1});
    rd_only(dv, f, d, oe_ok);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [7:0] f; logic [15:0] d; logic ok; int base; logic [5:0] DEV;
    rst_n = 1'b0; bclk = 1'b1; bmode = 1'b0; bdin = 1'b0; strap = 2'b10;
    DEV = dev_of(strap);
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk("R11 oe after reset", boe, 0);
    chk("R11 wr strobe after reset", rwr, 0);
    chk("R11 rd strobe after reset", rrd, 0);

    // R10: first pulse only wakes, so this whole write is lost
    wr(DEV, 7'd3, 16'h1234);
    chk("R10 no write before wake", wr_count, 0);
    wr(DEV, 7'd3, 16'h1234);
    chk("R10 write after wake count", wr_count, 1);
    chk("R10 write after wake data", {last_wa, last_wd}, {7'd3, 16'h1234});

    // R8: read with no prepare
    rd_only(DEV, f, d, ok);
    chk("R8 flag byte no prepare", f, 8'h01);
    chk("R8 data no prepare", d, 0);
    chk("R8 no rd strobe", rd_count, 0);

    // R4 / R6 sweep over every implemented register
    for (int a = 0; a < NIMPL; a++) begin
      base = wr_count;
      wr(DEV, 7'(a), pat(a));
      chk("R4 one strobe per write", wr_count - base, 1);
      chk("R4 write addr/data", {last_wa, last_wd}, {7'(a), pat(a)});
    end
    for (int a = 0; a < NIMPL; a++) begin
      rd(DEV, 7'(a), f, d, ok);
      chk("R6 status byte", f, {7'(a), 1'b0});
      chk("R6 read data", d, pat(a));
      chk("R9 oe during read bytes only", ok, 1);
    end

    // R7: unimplemented addresses
    foreach (mem[i]) ;
    for (int k = 0; k < 3; k++) begin
      logic [6:0] ua;
      ua = (k == 0) ? 7'd16 : (k == 1) ? 7'd77 : 7'd127;
      base = wr_count;
      wr(DEV, ua, 16'hBEEF);
      chk("R7 write to missing reg dropped", wr_count - base, 0);
      rd(DEV, ua, f, d, ok);
      chk("R7 missing reg flag", f, {ua, 1'b1});
      chk("R7 missing reg data zero", d, 0);
    end

    // R5: extra bytes after a completed write are ignored
    base = wr_count;
    set_mode(1'b0); send({DEV, 2'b10});
    set_mode(1'b1); send({7'd5, 1'b0}); send(8'h5A); send(8'hC3);
    send({7'd6, 1'b0}); send(8'h11); send(8'h22);
    set_mode(1'b0);
    chk("R5 single strobe in session", wr_count - base, 1);
    rd(DEV, 7'd6, f, d, ok);
    chk("R5 reg 6 untouched", d, pat(6));
    rd(DEV, 7'd5, f, d, ok);
    chk("R5 reg 5 written", d, 16'h5AC3);

    // R3: sweep all device addresses, only the matching one writes
    for (int v = 0; v < 64; v++) begin
      base = wr_count;
      wr(6'(v), 7'd9, 16'h0F00 + 16'(v));
      chk("R3 address match", wr_count - base, (6'(v) == DEV) ? 1 : 0);
    end
    rd(DEV, 7'd9, f, d, ok);
    chk("R3 reg 9 from matching address", d, 16'h0F00 + 16'(DEV));

    // R2: unused transfer codes
    for (int c = 0; c < 2; c++) begin
      base = wr_count;
      set_mode(1'b0); send({DEV, 2'(c)});
      set_mode(1'b1); send({7'd2, 1'b0}); send(8'h77); send(8'h88);
      chk("R2 unused code no drive", boe, 0);
      set_mode(1'b0);
      chk("R2 unused code no strobe", wr_count - base, 0);
    end

    // R1: each strap value with its own address
    for (int s = 0; s < 4; s++) begin
      strap = 2'(s);
      wr(dev_of(2'(s)), 7'd10, 16'h3C00 | 16'(s));
      rd(dev_of(2'(s)), 7'd10, f, d, ok);
      chk("R1 strap address write/read", d, 16'h3C00 | 16'(s));
      chk("R1 strap status byte", f, {7'd10, 1'b0});
    end
    strap = 2'b10;

    // R9: read cut short by mode falling
    set_mode(1'b0); send({DEV, 2'b10});
    set_mode(1'b1); send({7'd4, 1'b1});
    set_mode(1'b0); send({DEV, 2'b11});
    set_mode(1'b1); recv(f, ok);
    chk("R9 driving mid-read", boe, 1);
    @(negedge clk); bmode = 1'b0; #1;
    chk("R9 release on mode fall", boe, 0);
    repeat (3) @(negedge clk);
    chk("R9 never driven with mode low", oe_bad, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule